// File: doc/BRIEF.md
# Zero-turnaround pipelined SRAM core

A synchronous single-port memory with a fixed two-edge pipeline. An address and a command are captured on one rising clock edge. The data for that command moves exactly two enabled edges later. A write takes its data from `data_in` on that edge. A read drives its word from the output register loaded on that edge. Because both directions share the same latency, a controller can alternate reads and writes on every cycle and never has to insert an idle cycle to turn the bus around.

A load command starts a four-beat burst. Advance cycles then step the low two address bits, either by counting or by XOR with the beat number, while keeping the load's direction. A high clock enable freezes every register, as if that edge never happened. A deselect ends any burst, and commands already in flight still complete. Four 9-bit byte lanes can each be masked on writes. When a read follows a write to the same word while that write is not yet committed, the read returns the pending bytes merged over the stored word.

Top module: `zbt_sram_core`

## Requirements
- R1: After reset no operation is pending, `data_oe` is 0 and `data_out` is all zeros.
- R2: A read loaded on enabled edge N makes `data_oe` 1 and `data_out` the word only in the cycle after enabled edge N+2. Before that edge, and after edge N+3 unless another read follows, `data_oe` is 0.
- R3: A write loaded on enabled edge N stores the value of `data_in` sampled on enabled edge N+2, and a later read of that address returns it.
- R4: Reads and writes may be loaded on consecutive edges in any mix, with no idle cycle, and each one transfers correct data.
- R5: For a write, `byte_we_n[i]` = 0 updates bits [9i+8:9i] and `byte_we_n[i]` = 1 keeps them. On reads `byte_we_n` and `data_in` have no effect on memory.
- R6: A read loaded one edge after a write to the same address returns the write's enabled bytes merged over the stored word.
- R7: While `clk_en_n` = 1, every other synchronous input is ignored and all pipeline state, including `data_out`, holds. The data timing of pending operations shifts by one cycle for each frozen edge.
- R8: A load cycle (`adv_ld` = 0) with `sel_a_n` = 1, `sel_b_n` = 1 or `sel_c` = 0 starts no operation and ends any burst. Operations already in flight still complete. `data_oe` is 0 after the second enabled edge following a deselect or a write.
- R9: `out_en_n` = 1 forces `data_oe` to 0 and `data_out` to zeros at once, without disturbing the pipeline. Lowering it again shows the pending read word in the same cycle.
- R10: `adv_ld` = 1 after a selected load continues the burst. Beat k (1..3, then wrapping) uses the load address with its low two bits replaced by (base+k) mod 4 when `burst_ilv` = 0, or by base XOR k when `burst_ilv` = 1. The upper bits stay fixed, the direction comes from the load, and `wr_n`, `addr` and the chip enables are ignored.
- R11: `adv_ld` = 1 with no burst active (after reset or a deselect) starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| addr | input | ADDR_W | Word address, taken on load cycles |
| wr_n | input | 1 | Direction of a load: 0 write, 1 read |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the burst |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b_n | input | 1 | Chip enable, active low |
| sel_c | input | 1 | Chip enable, active high |
| byte_we_n | input | LANES | Active-low write mask, one bit per 9-bit lane |
| burst_ilv | input | 1 | Burst order: 0 counting, 1 XOR |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| data_in | input | LANES*LANE_W | Write data, sampled two edges after the command |
| data_out | output | LANES*LANE_W | Read data, zeros when not driving |
| data_oe | output | 1 | High while data_out carries read data |

## Verification
A write is held one stage after its data is captured. A read issued on the very next edge therefore looks up the array in the same cycle that this write is waiting to commit. This is the collision the bench aims at. It loads a write and then, on the following edge, a read of the same word. It repeats this with a full mask and with an alternating lane mask over a known old word, and expects the new bytes merged lane by lane in exactly the read's data cycle. A frozen edge placed between a read's load and its data edge is also checked: the data cycle must slip by exactly one cycle, and the garbage write offered during the freeze must leave no trace.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int BURST_LEN = 4;
    localparam int BURST_W   = $clog2(BURST_LEN);

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // low address bits of a burst beat
    function automatic logic [BURST_W-1:0] burst_offset(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] beat,
        input logic               xor_order
    );
        return xor_order ? (start ^ beat) : BURST_W'(start + beat);
    endfunction

endpackage

// File: rtl/zbt_cmd_front.sv
module zbt_cmd_front
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_n,
    input  logic              adv_ld,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              sel_c,
    input  logic [LANES-1:0]  byte_we_n,
    input  logic              burst_ilv,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_be_n
);

    typedef struct packed {
        logic               active;
        op_e                kind;
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] beat;
        op_e                op;
        logic [ADDR_W-1:0]  addr;
        logic [LANES-1:0]   be_n;
    } front_t;

    front_t st_d, st_q;
    logic   chip_sel;

    assign chip_sel = !sel_a_n && !sel_b_n && sel_c;

    always_comb begin
        st_d = st_q;
        if (!clk_en_n) begin
            if (!adv_ld) begin
                if (chip_sel) begin
                    st_d.active = 1'b1;
                    st_d.kind   = wr_n ? OP_READ : OP_WRITE;
                    st_d.base   = addr;
                    st_d.beat   = '0;
                    st_d.op     = st_d.kind;
                    st_d.addr   = addr;
                    st_d.be_n   = byte_we_n;
                end else begin
                    st_d.active = 1'b0;
                    st_d.op     = OP_NONE;
                end
            end else if (st_q.active) begin
                st_d.beat = st_q.beat + BURST_W'(1);
                st_d.op   = st_q.kind;
                st_d.addr = {st_q.base[ADDR_W-1:BURST_W],
                             burst_offset(st_q.base[BURST_W-1:0], st_d.beat, burst_ilv)};
                st_d.be_n = byte_we_n;
            end else begin
                st_d.op = OP_NONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s1_op   = st_q.op;
    assign s1_addr = st_q.addr;
    assign s1_be_n = st_q.be_n;

    assert_deselect_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld && !chip_sel) |=> (s1_op == OP_NONE));

    assert_load_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !adv_ld && chip_sel) |=> (s1_op != OP_NONE && s1_addr == $past(addr)));

    assert_linear_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld && st_q.active && !burst_ilv) |=>
        (s1_addr[BURST_W-1:0] == BURST_W'($past(s1_addr[BURST_W-1:0]) + 1'b1)) &&
        (s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W])));

    assert_advance_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && adv_ld && !st_q.active) |=> (s1_op == OP_NONE));

endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_be_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && !wr_be_n[g])
                cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/zbt_fwd_merge.sv
module zbt_fwd_merge #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [LANES*LANE_W-1:0] arr_data,
    input  logic                    pend_valid,
    input  logic [ADDR_W-1:0]       pend_addr,
    input  logic [LANES-1:0]        pend_be_n,
    input  logic [LANES*LANE_W-1:0] pend_data,
    output logic [LANES*LANE_W-1:0] merged
);

    logic hit;
    assign hit = pend_valid && (pend_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_mix
        assign merged[g*LANE_W +: LANE_W] = (hit && !pend_be_n[g])
                                          ? pend_data[g*LANE_W +: LANE_W]
                                          : arr_data[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr_n,
    input  logic                    adv_ld,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    sel_c,
    input  logic [LANES-1:0]        byte_we_n,
    input  logic                    burst_ilv,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] data_in,
    output logic [LANES*LANE_W-1:0] data_out,
    output logic                    data_oe
);

    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        op_e               s2_op;
        logic [ADDR_W-1:0] s2_addr;
        logic [LANES-1:0]  s2_be_n;
        logic              s3_vld;
        logic [ADDR_W-1:0] s3_addr;
        logic [LANES-1:0]  s3_be_n;
        logic [DATA_W-1:0] s3_data;
        logic              rd_vld;
        logic [DATA_W-1:0] dout;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_be_n;
    logic [DATA_W-1:0] arr_rd;
    logic [DATA_W-1:0] fwd_rd;
    logic              commit;

    zbt_cmd_front #(.ADDR_W(ADDR_W), .LANES(LANES)) u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_n  (clk_en_n),
        .addr      (addr),
        .wr_n      (wr_n),
        .adv_ld    (adv_ld),
        .sel_a_n   (sel_a_n),
        .sel_b_n   (sel_b_n),
        .sel_c     (sel_c),
        .byte_we_n (byte_we_n),
        .burst_ilv (burst_ilv),
        .s1_op     (s1_op),
        .s1_addr   (s1_addr),
        .s1_be_n   (s1_be_n)
    );

    assign commit = !clk_en_n && pipe_q.s3_vld;

    zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_en   (commit),
        .wr_addr (pipe_q.s3_addr),
        .wr_be_n (pipe_q.s3_be_n),
        .wr_data (pipe_q.s3_data),
        .rd_addr (pipe_q.s2_addr),
        .rd_data (arr_rd)
    );

    zbt_fwd_merge #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .rd_addr    (pipe_q.s2_addr),
        .arr_data   (arr_rd),
        .pend_valid (pipe_q.s3_vld),
        .pend_addr  (pipe_q.s3_addr),
        .pend_be_n  (pipe_q.s3_be_n),
        .pend_data  (pipe_q.s3_data),
        .merged     (fwd_rd)
    );

    always_comb begin
        pipe_d = pipe_q;
        if (!clk_en_n) begin
            pipe_d.s2_op   = s1_op;
            pipe_d.s2_addr = s1_addr;
            pipe_d.s2_be_n = s1_be_n;
            pipe_d.s3_vld  = (pipe_q.s2_op == OP_WRITE);
            pipe_d.s3_addr = pipe_q.s2_addr;
            pipe_d.s3_be_n = pipe_q.s2_be_n;
            pipe_d.s3_data = data_in;
            pipe_d.rd_vld  = (pipe_q.s2_op == OP_READ);
            if (pipe_q.s2_op == OP_READ)
                pipe_d.dout = fwd_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign data_oe  = pipe_q.rd_vld && !out_en_n;
    assign data_out = data_oe ? pipe_q.dout : '0;

    assert_read_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && pipe_q.s2_op == OP_READ) |=> pipe_q.rd_vld);

    assert_bus_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && pipe_q.s2_op != OP_READ) |=> !data_oe);

    assert_write_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && pipe_q.s2_op == OP_WRITE) |=>
        (pipe_q.s3_vld && pipe_q.s3_data == $past(data_in)));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(pipe_q) && $stable(s1_op) && $stable(s1_addr)));

endmodule

// File: tb/sim_zbt_sram_core.sv
module sim_zbt_sram_core;

    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int DATA_W = LANES * LANE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clk_en_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_n = 1'b1;
    logic              adv_ld = 1'b0;
    logic              sel_a_n = 1'b0;
    logic              sel_b_n = 1'b0;
    logic              sel_c = 1'b0;
    logic [LANES-1:0]  byte_we_n = '1;
    logic              burst_ilv = 1'b0;
    logic              out_en_n = 1'b0;
    logic [DATA_W-1:0] data_in = '0;
    logic [DATA_W-1:0] data_out;
    logic              data_oe;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [DATA_W-1:0] D1   = 36'h1_2345_6789;
    localparam logic [DATA_W-1:0] GARB = 36'hF_FFFF_FFFF;

    always #(CLK_P/2) clk = ~clk;

    zbt_sram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .addr(addr), .wr_n(wr_n),
        .adv_ld(adv_ld), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .byte_we_n(byte_we_n), .burst_ilv(burst_ilv), .out_en_n(out_en_n),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
    );

    task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] lane_mix(logic [DATA_W-1:0] old_v,
                                                   logic [DATA_W-1:0] new_v,
                                                   logic [LANES-1:0] be_n);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[i*LANE_W +: LANE_W] = be_n[i] ? old_v[i*LANE_W +: LANE_W]
                                            : new_v[i*LANE_W +: LANE_W];
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic c_idle();
        clk_en_n = 1'b0; adv_ld = 1'b0; sel_a_n = 1'b0; sel_b_n = 1'b0;
        sel_c = 1'b0; wr_n = 1'b1;
    endtask

    task automatic c_load(logic is_wr, logic [ADDR_W-1:0] a, logic [LANES-1:0] be);
        clk_en_n = 1'b0; adv_ld = 1'b0; sel_a_n = 1'b0; sel_b_n = 1'b0;
        sel_c = 1'b1; wr_n = ~is_wr; addr = a; byte_we_n = be;
    endtask

    task automatic c_adv(logic wr_level, logic [LANES-1:0] be);
        clk_en_n = 1'b0; adv_ld = 1'b1; sel_c = 1'b0;
        wr_n = wr_level; addr = ~addr; byte_we_n = be;
    endtask

    task automatic write_word(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, logic [LANES-1:0] be);
        c_load(1'b1, a, be); tick();
        c_idle(); tick();
        data_in = d; tick();
        data_in = '0; tick();
    endtask

    task automatic read_check(string tag, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] exp);
        c_load(1'b0, a, '1); tick();
        c_idle(); tick();
        tick();
        chk({tag, " oe"}, DATA_W'(data_oe), DATA_W'(1));
        chk({tag, " data"}, data_out, exp);
        tick();
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", DATA_W'(data_oe), '0);
        chk("R1 data after reset", data_out, '0);
        // advance with no burst loaded (R11)
        data_in = GARB;
        for (int i = 0; i < 3; i++) begin
            c_adv(1'b1, '1); tick();
        end
        c_idle(); tick(); tick();
        chk("R11 no read from advance after reset", DATA_W'(data_oe), '0);
        data_in = '0;
    endtask

    task automatic t_latency();
        write_word(8'h10, D1, '0);
        c_load(1'b0, 8'h10, '1); tick();
        c_idle(); tick();
        chk("R2 not driven at N+1", DATA_W'(data_oe), '0);
        tick();
        chk("R2 driven at N+2", DATA_W'(data_oe), DATA_W'(1));
        chk("R3 read back written word", data_out, D1);
        tick();
        chk("R2 single beat", DATA_W'(data_oe), '0);
    endtask

    task automatic t_mixed();
        logic [DATA_W-1:0] w0 = 36'hA_5A5A_5A5A;
        logic [DATA_W-1:0] w1 = 36'h3_C3C3_C3C3;
        c_load(1'b1, 8'h20, '0); tick();
        c_load(1'b0, 8'h10, '1); tick();
        c_load(1'b1, 8'h21, '0); data_in = w0; tick();
        c_load(1'b0, 8'h20, '1); tick();
        chk("R4 read between writes", data_out, D1);
        c_idle(); data_in = w1; tick();
        chk("R8 bus released after write", DATA_W'(data_oe), '0);
        data_in = '0; tick();
        chk("R4 read right after write data", data_out, w0);
        tick();
        read_check("R4 second write", 8'h21, w1);
    endtask

    task automatic t_forward();
        logic [DATA_W-1:0] w2 = 36'h7_0F0F_0F0F;
        logic [DATA_W-1:0] p  = 36'h1_1111_1111;
        logic [DATA_W-1:0] q  = 36'hE_EEEE_EEEE;
        c_load(1'b1, 8'h30, '0); tick();
        c_load(1'b0, 8'h30, '1); tick();
        c_idle(); data_in = w2; tick();
        data_in = '0; tick();
        chk("R6 full forward", data_out, w2);
        write_word(8'h31, p, '0);
        c_load(1'b1, 8'h31, 4'b1010); tick();
        c_load(1'b0, 8'h31, '1); tick();
        c_idle(); data_in = q; tick();
        data_in = '0; tick();
        chk("R6 lane forward", data_out, lane_mix(p, q, 4'b1010));
        tick();
        read_check("R6 after commit", 8'h31, lane_mix(p, q, 4'b1010));
    endtask

    task automatic t_bytes();
        logic [DATA_W-1:0] x = 36'h2_4681_3579;
        logic [DATA_W-1:0] d = 36'hD_B975_0ECA;
        write_word(8'h40, x, '0);
        write_word(8'h40, d, 4'b0110);
        read_check("R5 lane mask", 8'h40, lane_mix(x, d, 4'b0110));
        c_load(1'b0, 8'h40, 4'b0000); tick();
        c_idle(); tick();
        data_in = GARB; tick();
        chk("R5 read ignores mask", data_out, lane_mix(x, d, 4'b0110));
        data_in = '0; tick();
        read_check("R5 memory untouched by read", 8'h40, lane_mix(x, d, 4'b0110));
    endtask

    task automatic t_stall();
        c_load(1'b0, 8'h10, '1); tick();
        c_idle(); tick();
        clk_en_n = 1'b1; sel_c = 1'b1; wr_n = 1'b0; addr = 8'h10;
        byte_we_n = '0; data_in = GARB; tick();
        chk("R7 frozen edge delays read", DATA_W'(data_oe), '0);
        c_idle(); data_in = '0; tick();
        chk("R7 read after freeze", data_out, D1);
        clk_en_n = 1'b1; sel_c = 1'b1; wr_n = 1'b0; data_in = GARB; tick();
        chk("R7 output held oe", DATA_W'(data_oe), DATA_W'(1));
        chk("R7 output held data", data_out, D1);
        c_idle(); data_in = '0; tick();
        chk("R7 release after freeze", DATA_W'(data_oe), '0);
        tick();
        read_check("R7 no write while frozen", 8'h10, D1);
    endtask

    task automatic t_deselect();
        for (int k = 0; k < 3; k++) begin
            c_load(1'b0, 8'h10, '1);
            if (k == 0) sel_a_n = 1'b1;
            if (k == 1) sel_b_n = 1'b1;
            if (k == 2) sel_c = 1'b0;
            tick();
            c_idle(); tick(); tick();
            chk("R8 deselected read", DATA_W'(data_oe), '0);
        end
        c_load(1'b1, 8'h10, '0); sel_b_n = 1'b1; tick();
        c_idle(); tick();
        data_in = GARB; tick();
        data_in = '0; tick();
        read_check("R8 deselected write", 8'h10, D1);
        c_load(1'b0, 8'h10, '1); tick();
        c_idle(); tick(); tick();
        chk("R8 pending read completes", data_out, D1);
        tick();
        chk("R8 tri-state after deselect", DATA_W'(data_oe), '0);
    endtask

    task automatic t_oe();
        c_load(1'b0, 8'h10, '1); tick();
        c_idle(); tick();
        out_en_n = 1'b1; tick();
        chk("R9 oe forced off", DATA_W'(data_oe), '0);
        chk("R9 data forced zero", data_out, '0);
        out_en_n = 1'b0; #1;
        chk("R9 data back", data_out, D1);
        tick();
    endtask

    task automatic burst_read(string tag, logic [ADDR_W-1:0] base, logic ilv,
                              logic [DATA_W-1:0] e0, logic [DATA_W-1:0] e1,
                              logic [DATA_W-1:0] e2, logic [DATA_W-1:0] e3);
        burst_ilv = ilv;
        c_load(1'b0, base, '1); tick();
        c_adv(1'b0, '0); tick();
        c_adv(1'b0, '0); tick();
        chk({tag, " beat0"}, data_out, e0);
        c_adv(1'b0, '0); tick();
        chk({tag, " beat1"}, data_out, e1);
        c_idle(); tick();
        chk({tag, " beat2"}, data_out, e2);
        tick();
        chk({tag, " beat3"}, data_out, e3);
        tick();
        burst_ilv = 1'b0;
    endtask

    task automatic t_burst();
        logic [DATA_W-1:0] b0 = 36'h0_0000_00B0;
        logic [DATA_W-1:0] b1 = 36'h0_0000_0B11;
        logic [DATA_W-1:0] b2 = 36'h0_0000_B222;
        logic [DATA_W-1:0] b3 = 36'h0_000B_3333;
        burst_ilv = 1'b0;
        c_load(1'b1, 8'h52, '0); tick();
        c_adv(1'b1, '0); tick();
        c_adv(1'b1, '0); data_in = b0; tick();
        c_adv(1'b1, '0); data_in = b1; tick();
        c_idle(); data_in = b2; tick();
        data_in = b3; tick();
        data_in = '0; tick();
        read_check("R10 linear write beat0", 8'h52, b0);
        read_check("R10 linear write beat1", 8'h53, b1);
        read_check("R10 linear wrap beat2", 8'h50, b2);
        read_check("R10 linear wrap beat3", 8'h51, b3);
        burst_read("R10 xor read", 8'h51, 1'b1, b3, b2, b1, b0);
        burst_read("R10 linear read", 8'h53, 1'b0, b1, b2, b3, b0);
    endtask

    task automatic t_adv_after_deselect();
        logic [DATA_W-1:0] keep = 36'h6_6666_6666;
        write_word(8'h61, keep, '0);
        write_word(8'h60, D1, '0);
        c_idle(); tick();
        data_in = GARB;
        for (int i = 0; i < 3; i++) begin
            c_adv(1'b0, '0); tick();
        end
        c_idle(); tick();
        chk("R11 no op after deselect", DATA_W'(data_oe), '0);
        data_in = '0; tick(); tick();
        read_check("R11 burst ended by deselect", 8'h61, keep);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        c_idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_mixed();
        t_forward();
        t_bytes();
        t_stall();
        t_deselect();
        t_oe();
        t_burst();
        t_adv_after_deselect();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule